// File: doc/BRIEF.md
# Flash command decoder

This block is the command front end of a block-erasable flash device. It watches the device's bus control pins, treats each rising edge of the active-low write enable as a bus write cycle, and interprets the byte written as a command or as the second cycle of a two-cycle sequence. From these commands it chooses what a bus read returns: array data, identifier codes, the compatible status byte, or the extended status (a global byte and one byte per erase block). It also issues single-cycle start pulses to a write engine, which sits outside the block and reports back through a busy level and a done pulse.

Status is kept in three groups. The compatible status byte holds the ready, suspended, erase-error and write-error flags. The global byte holds ready and a summary error flag. Each erase block has a status byte holding ready, its lock bit and an operation-error bit. Lock bits read as locked after reset until an upload command copies in the nonvolatile lock values. While write-protect is low, a locked block refuses writes and erases. A clear command wipes the error flags in all three groups.

All inputs are sampled on `clk`. The bus pins are assumed to be already synchronous to it, and the rising edge of the write enable is found by comparing two samples.

Top module: `flash_cmd_decoder`

## Requirements
- R1: `dout_en` is 1 only while `ce0_n`, `ce1_n` and `oe_n` are all low, and `dout` reads 00h whenever `dout_en` is 0. A write cycle is ignored if either chip enable is high or `oe_n` is low when `we_n` rises.
- R2: A bus write takes effect at the rising edge of `we_n`. The address and data are the values present at that edge, not the values present while `we_n` was low.
- R3: Read-mode commands: FFh selects array mode (`rd_mode`=0, `dout`=`array_rdata`). 90h selects identifier mode (`rd_mode`=1; address bit 0 = 0 reads 89h, bit 0 = 1 reads A0h). 70h selects compatible status (`rd_mode`=2). 71h selects extended status (`rd_mode`=3; address bit 0 = 1 reads the global byte, 0 reads the status byte of the block given by the top `BLK_W` address bits). An unrecognised first-cycle byte selects array mode.
- R4: 40h or 10h followed by a second write cycle produces a one-cycle `start_write`, with `op_addr`/`op_data` equal to the second cycle's address and data, and sets `rd_mode` to 2. The first cycle alone starts nothing.
- R5: 20h followed by D0h produces a one-cycle `start_erase`, with `op_addr` equal to the confirm cycle's address, and sets `rd_mode` to 2.
- R6: 20h followed by any byte other than D0h starts nothing. It sets compatible status bits 5 and 4 and global bit 5, and returns `rd_mode` to 0.
- R7: B0h while an erase is in progress (after `start_erase` and before `eng_done`) produces `start_suspend`, sets compatible bit 6 and `rd_mode` 2. D0h while suspended produces `start_resume` and clears bit 6. B0h with no erase in progress has no effect. At most one start pulse is high in any cycle.
- R8: While `wp_n` is low, a write or erase aimed at a block whose lock bit (block status bit 6) is 1 produces no start pulse. It sets compatible bit 4 (write) or bit 5 (erase), global bit 5, and bit 5 of that block's status byte, and `rd_mode` becomes 2. While `wp_n` is high, locked blocks accept the operation.
- R9: After reset every block status byte has bit 6 = 1. Command 97h copies `lock_nv` into the lock bits and leaves `rd_mode` unchanged.
- R10: Command 50h clears compatible bits 5, 4 and 3, global bit 5, and bits 5, 4 and 2 of every block status byte. It leaves lock bits and `rd_mode` unchanged.
- R11: While `rst_n` is low, start pulses and error flags are cleared and any half-entered sequence or suspension is dropped. After release `rd_mode` is 0.
- R12: Bit 7 of the compatible, global and every block status byte equals the inverse of `eng_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset and abort |
| ce0_n | input | 1 | Chip enable 0, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; rising edge commits a cycle |
| wp_n | input | 1 | Write protect, low honours lock bits |
| addr | input | ADDR_W | Bus address; top BLK_W bits pick the block |
| din | input | 8 | Bus write data / command byte |
| array_rdata | input | 8 | Array data returned in array mode |
| lock_nv | input | 2**BLK_W | Nonvolatile lock values loaded by upload |
| eng_busy | input | 1 | Write engine busy |
| eng_done | input | 1 | One-cycle pulse when an erase finishes |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data valid / drive enable |
| rd_mode | output | 2 | Current read mode (0 array, 1 id, 2 status, 3 extended) |
| start_write | output | 1 | Start a word/byte write |
| start_erase | output | 1 | Start a block erase |
| start_suspend | output | 1 | Suspend the running erase |
| start_resume | output | 1 | Resume the suspended erase |
| op_addr | output | ADDR_W | Address of the started operation |
| op_data | output | 8 | Data of the started write |

## Verification
The bench changes the data byte while the write enable is low and again as it rises. A decoder that latched on the falling edge would land in identifier mode instead of status mode. It sends a non-confirm byte after an erase setup, which a careless sequencer would ignore or treat as a fresh command, and it aims writes and erases at locked blocks with protection both on and off, so that a design that skips the lock lookup or reports the wrong error bit is exposed. It also checks that clear leaves lock bits intact, that a suspend with no erase running does nothing, and that reset drops a half-entered write sequence and relocks every block.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0,
        RM_IDENT = 2'd1,
        RM_CSR   = 2'd2,
        RM_EXT   = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WDATA = 2'd1,
        SQ_ECONF = 2'd2
    } seq_st_e;

    // status update events produced by the sequencer
    typedef struct packed {
        logic wr_err;
        logic er_err;
        logic blk_err;
        logic clr;
        logic upload;
    } stat_ev_t;

    localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OP_IDENT      = 8'h90;
    localparam logic [7:0] OP_READ_CSR   = 8'h70;
    localparam logic [7:0] OP_READ_EXT   = 8'h71;
    localparam logic [7:0] OP_CLEAR      = 8'h50;
    localparam logic [7:0] OP_WRITE_A    = 8'h40;
    localparam logic [7:0] OP_WRITE_B    = 8'h10;
    localparam logic [7:0] OP_ERASE      = 8'h20;
    localparam logic [7:0] OP_SUSPEND    = 8'hB0;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_UPLOAD     = 8'h97;

endpackage

// File: rtl/fcd_bus_qual.sv
module fcd_bus_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic ce0_n,
    input  logic ce1_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_stb,
    output logic rd_en
);
    typedef struct packed {
        logic we;
    } bq_t;

    bq_t q, d;
    logic sel;

    always_comb begin
        d      = q;
        d.we   = we_n;
        sel    = !ce0_n && !ce1_n;
        // chip enable over output enable over write enable
        rd_en  = sel && !oe_n;
        wr_stb = sel && oe_n && !q.we && we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{we: 1'b1};
        else        q <= d;
    end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int BLK_W  = 5,
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              wp_n,
    input  logic [NBLK-1:0]   lock_bits,
    input  logic              eng_done,
    output rd_mode_e          rd_mode,
    output logic              start_write,
    output logic              start_erase,
    output logic              start_suspend,
    output logic              start_resume,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              suspended,
    output stat_ev_t          ev,
    output logic [BLK_W-1:0]  ev_blk
);
    typedef struct packed {
        seq_st_e           st;
        rd_mode_e          mode;
        logic              p_wr;
        logic              p_er;
        logic              p_su;
        logic              p_re;
        logic [ADDR_W-1:0] oa;
        logic [7:0]        od;
        logic              er_act;
        logic              susp;
    } seq_t;

    seq_t q, d;
    logic [BLK_W-1:0] blk;
    logic             prot;

    always_comb begin
        d      = q;
        d.p_wr = 1'b0;
        d.p_er = 1'b0;
        d.p_su = 1'b0;
        d.p_re = 1'b0;
        ev     = '0;
        blk    = addr[ADDR_W-1 -: BLK_W];
        prot   = !wp_n && lock_bits[blk];

        if (eng_done) begin
            d.er_act = 1'b0;
            d.susp   = 1'b0;
        end

        if (wr_stb) begin
            case (q.st)
                SQ_WDATA: begin
                    d.st   = SQ_IDLE;
                    d.mode = RM_CSR;
                    if (prot) begin
                        ev.wr_err  = 1'b1;
                        ev.blk_err = 1'b1;
                    end else begin
                        d.p_wr = 1'b1;
                        d.oa   = addr;
                        d.od   = din;
                    end
                end
                SQ_ECONF: begin
                    d.st = SQ_IDLE;
                    if (din == OP_CONFIRM) begin
                        d.mode = RM_CSR;
                        if (prot) begin
                            ev.er_err  = 1'b1;
                            ev.blk_err = 1'b1;
                        end else begin
                            d.p_er   = 1'b1;
                            d.oa     = addr;
                            d.er_act = 1'b1;
                        end
                    end else begin
                        // broken erase sequence
                        ev.wr_err = 1'b1;
                        ev.er_err = 1'b1;
                        d.mode    = RM_ARRAY;
                    end
                end
                default: begin
                    if (q.susp && din == OP_CONFIRM) begin
                        d.p_re = 1'b1;
                        d.susp = 1'b0;
                        d.mode = RM_CSR;
                    end else begin
                        case (din)
                            OP_READ_ARRAY: d.mode = RM_ARRAY;
                            OP_IDENT:      d.mode = RM_IDENT;
                            OP_READ_CSR:   d.mode = RM_CSR;
                            OP_READ_EXT:   d.mode = RM_EXT;
                            OP_CLEAR:      ev.clr = 1'b1;
                            OP_UPLOAD:     ev.upload = 1'b1;
                            OP_WRITE_A,
                            OP_WRITE_B:    d.st = SQ_WDATA;
                            OP_ERASE:      d.st = SQ_ECONF;
                            OP_SUSPEND: begin
                                if (q.er_act && !q.susp) begin
                                    d.p_su = 1'b1;
                                    d.susp = 1'b1;
                                    d.mode = RM_CSR;
                                end
                            end
                            default:       d.mode = RM_ARRAY;
                        endcase
                    end
                end
            endcase
        end

        ev_blk        = blk;
        rd_mode       = q.mode;
        start_write   = q.p_wr;
        start_erase   = q.p_er;
        start_suspend = q.p_su;
        start_resume  = q.p_re;
        op_addr       = q.oa;
        op_data       = q.od;
        suspended     = q.susp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/fcd_status.sv
module fcd_status
    import fcd_pkg::*;
#(
    parameter int BLK_W = 5,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stat_ev_t         ev,
    input  logic [BLK_W-1:0] ev_blk,
    input  logic [NBLK-1:0]  lock_nv,
    output logic             csr_er,
    output logic             csr_wr,
    output logic             gsr_err,
    output logic [NBLK-1:0]  lock_q,
    output logic [NBLK-1:0]  berr_q
);
    typedef struct packed {
        logic [NBLK-1:0] lock;
        logic [NBLK-1:0] berr;
        logic            er;
        logic            wr;
        logic            gerr;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (ev.clr) begin
            d.er   = 1'b0;
            d.wr   = 1'b0;
            d.gerr = 1'b0;
            d.berr = '0;
        end
        if (ev.wr_err) d.wr = 1'b1;
        if (ev.er_err) d.er = 1'b1;
        if (ev.wr_err || ev.er_err) d.gerr = 1'b1;
        if (ev.blk_err) d.berr[ev_blk] = 1'b1;
        if (ev.upload) d.lock = lock_nv;

        csr_er  = q.er;
        csr_wr  = q.wr;
        gsr_err = q.gerr;
        lock_q  = q.lock;
        berr_q  = q.berr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.lock <= '1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux
    import fcd_pkg::*;
#(
    parameter int         BLK_W    = 5,
    parameter logic [7:0] MFR_CODE = 8'h89,
    parameter logic [7:0] DEV_CODE = 8'hA0,
    localparam int        NBLK     = 1 << BLK_W
) (
    input  logic             rd_en,
    input  rd_mode_e         rd_mode,
    input  logic             a0,
    input  logic [BLK_W-1:0] blk,
    input  logic [7:0]       array_rdata,
    input  logic             eng_busy,
    input  logic             suspended,
    input  logic             csr_er,
    input  logic             csr_wr,
    input  logic             gsr_err,
    input  logic [NBLK-1:0]  lock_q,
    input  logic [NBLK-1:0]  berr_q,
    output logic [7:0]       dout,
    output logic             dout_en
);
    logic [7:0] bsr_byte [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_bsr
        assign bsr_byte[b] = {~eng_busy, lock_q[b], berr_q[b], 5'b0};
    end

    always_comb begin
        dout_en = rd_en;
        dout    = 8'h00;
        if (rd_en) begin
            case (rd_mode)
                RM_ARRAY: dout = array_rdata;
                RM_IDENT: dout = a0 ? DEV_CODE : MFR_CODE;
                RM_CSR:   dout = {~eng_busy, suspended, csr_er, csr_wr, 4'b0};
                default:  dout = a0 ? {~eng_busy, 1'b0, gsr_err, 5'b0}
                                    : bsr_byte[blk];
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W   = 21,
    parameter int         BLK_W    = 5,
    parameter logic [7:0] MFR_CODE = 8'h89,
    parameter logic [7:0] DEV_CODE = 8'hA0,
    localparam int        NBLK     = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce0_n,
    input  logic              ce1_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [7:0]        array_rdata,
    input  logic [NBLK-1:0]   lock_nv,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic [1:0]        rd_mode,
    output logic              start_write,
    output logic              start_erase,
    output logic              start_suspend,
    output logic              start_resume,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);
    logic             wr_stb, rd_en, suspended;
    logic             csr_er, csr_wr, gsr_err;
    logic [NBLK-1:0]  lock_q, berr_q;
    stat_ev_t         ev;
    logic [BLK_W-1:0] ev_blk;
    rd_mode_e         mode_w;

    fcd_bus_qual u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce0_n  (ce0_n),
        .ce1_n  (ce1_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .wr_stb (wr_stb),
        .rd_en  (rd_en)
    );

    fcd_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_stb        (wr_stb),
        .addr          (addr),
        .din           (din),
        .wp_n          (wp_n),
        .lock_bits     (lock_q),
        .eng_done      (eng_done),
        .rd_mode       (mode_w),
        .start_write   (start_write),
        .start_erase   (start_erase),
        .start_suspend (start_suspend),
        .start_resume  (start_resume),
        .op_addr       (op_addr),
        .op_data       (op_data),
        .suspended     (suspended),
        .ev            (ev),
        .ev_blk        (ev_blk)
    );

    fcd_status #(.BLK_W(BLK_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .ev_blk  (ev_blk),
        .lock_nv (lock_nv),
        .csr_er  (csr_er),
        .csr_wr  (csr_wr),
        .gsr_err (gsr_err),
        .lock_q  (lock_q),
        .berr_q  (berr_q)
    );

    fcd_rdmux #(.BLK_W(BLK_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
        .rd_en       (rd_en),
        .rd_mode     (mode_w),
        .a0          (addr[0]),
        .blk         (addr[ADDR_W-1 -: BLK_W]),
        .array_rdata (array_rdata),
        .eng_busy    (eng_busy),
        .suspended   (suspended),
        .csr_er      (csr_er),
        .csr_wr      (csr_wr),
        .gsr_err     (gsr_err),
        .lock_q      (lock_q),
        .berr_q      (berr_q),
        .dout        (dout),
        .dout_en     (dout_en)
    );

    assign rd_mode = mode_w;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ce0_n,
    input logic       ce1_n,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic       dout_en,
    input logic [1:0] rd_mode,
    input logic       start_write,
    input logic       start_erase,
    input logic       start_suspend,
    input logic       start_resume
);
    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce0_n || ce1_n) |-> (!dout_en && dout == 8'h00));

    assert_write_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_write |=> !start_write);

    assert_write_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_write |-> rd_mode == 2'd2);

    assert_erase_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_erase |-> $past(din) == 8'hD0);

    assert_erase_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_erase |=> !start_erase);

    assert_susp_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_suspend || start_resume) |-> rd_mode == 2'd2);

    assert_one_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_write, start_erase, start_suspend, start_resume}));
endmodule

bind flash_cmd_decoder fcd_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ce0_n         (ce0_n),
    .ce1_n         (ce1_n),
    .din           (din),
    .dout          (dout),
    .dout_en       (dout_en),
    .rd_mode       (rd_mode),
    .start_write   (start_write),
    .start_erase   (start_erase),
    .start_suspend (start_suspend),
    .start_resume  (start_resume)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, ce0_n, ce1_n, oe_n, we_n, wp_n;
    logic [20:0] addr;
    logic [7:0]  din, array_rdata;
    logic [31:0] lock_nv;
    logic        eng_busy, eng_done;
    logic [7:0]  dout;
    logic        dout_en;
    logic [1:0]  rd_mode;
    logic        start_write, start_erase, start_suspend, start_resume;
    logic [20:0] op_addr;
    logic [7:0]  op_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1_n(ce1_n), .oe_n(oe_n),
        .we_n(we_n), .wp_n(wp_n), .addr(addr), .din(din),
        .array_rdata(array_rdata), .lock_nv(lock_nv), .eng_busy(eng_busy),
        .eng_done(eng_done), .dout(dout), .dout_en(dout_en), .rd_mode(rd_mode),
        .start_write(start_write), .start_erase(start_erase),
        .start_suspend(start_suspend), .start_resume(start_resume),
        .op_addr(op_addr), .op_data(op_data)
    );

    // {command, read address, expected mode, expected read byte}
    localparam logic [38:0] VEC [7] = '{
        {8'hFF, 21'h000000, 2'd0, 8'h5A},
        {8'h90, 21'h000000, 2'd1, 8'h89},
        {8'h90, 21'h000001, 2'd1, 8'hA0},
        {8'h70, 21'h000000, 2'd2, 8'h80},
        {8'h71, 21'h000001, 2'd3, 8'h80},
        {8'h71, 21'h030000, 2'd3, 8'hC0},
        {8'h33, 21'h000000, 2'd0, 8'h5A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [20:0] a, input logic [7:0] d,
                          input logic c1, input logic oe);
        @(negedge clk);
        ce0_n = 1'b0; ce1_n = c1; oe_n = oe; addr = a; din = d; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce1_n = 1'b0; oe_n = 1'b1;
        #1;
    endtask

    task automatic wr(input logic [20:0] a, input logic [7:0] d);
        wr_ctl(a, d, 1'b0, 1'b1);
    endtask

    task automatic rd(input logic [20:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; oe_n = 1'b0;
        #2 v = dout;
        oe_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; ce0_n = 1'b1; ce1_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        wp_n = 1'b1; addr = '0; din = '0; array_rdata = 8'h5A;
        lock_nv = '1; eng_busy = 1'b0; eng_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11 reset mode", rd_mode, 2'd0);
        chk("R11 reset pulses", {start_write, start_erase, start_suspend, start_resume}, 4'd0);
        chk("R1 reset dout_en", dout_en, 1'b0);

        // R3 read-mode table
        for (int i = 0; i < 7; i++) begin
            wr(21'h0, VEC[i][38:31]);
            chk("R3 mode", rd_mode, VEC[i][9:8]);
            rd(VEC[i][30:10], v);
            chk("R3 dout", v, VEC[i][7:0]);
        end

        // R1 selection
        @(negedge clk); ce1_n = 1'b1; ce0_n = 1'b0; oe_n = 1'b0; #1;
        chk("R1 deselected dout_en", dout_en, 1'b0);
        chk("R1 deselected dout", dout, 8'h00);
        oe_n = 1'b1; ce1_n = 1'b0;
        wr_ctl(21'h0, 8'h70, 1'b1, 1'b1);
        chk("R1 write while deselected", rd_mode, 2'd0);
        wr_ctl(21'h0, 8'h70, 1'b0, 1'b0);
        chk("R1 write while oe low", rd_mode, 2'd0);

        // R2 capture on rising edge
        @(negedge clk); ce0_n = 1'b0; ce1_n = 1'b0; addr = '0; din = 8'h90; we_n = 1'b0;
        @(negedge clk); din = 8'h70; we_n = 1'b1;
        @(negedge clk); #1;
        chk("R2 rising edge data", rd_mode, 2'd2);

        // R4 word/byte write
        wr(21'h0, 8'h40);
        chk("R4 setup alone", start_write, 1'b0);
        wr(21'h012345, 8'h3C);
        chk("R4 start", start_write, 1'b1);
        chk("R4 op_addr", op_addr, 21'h012345);
        chk("R4 op_data", op_data, 8'h3C);
        chk("R4 mode", rd_mode, 2'd2);
        @(negedge clk); #1;
        chk("R4 single cycle", start_write, 1'b0);
        wr(21'h0, 8'hFF);
        wr(21'h0, 8'h10);
        wr(21'h000012, 8'hA5);
        chk("R4 alt start", start_write, 1'b1);
        chk("R4 alt data", op_data, 8'hA5);

        // R5 erase
        wr(21'h0, 8'h20);
        wr(21'h040000, 8'hD0);
        chk("R5 start", start_erase, 1'b1);
        chk("R5 op_addr", op_addr, 21'h040000);

        // R7 suspend / resume
        wr(21'h0, 8'hB0);
        chk("R7 suspend", start_suspend, 1'b1);
        rd(21'h0, v);
        chk("R7 suspended csr", v, 8'hC0);
        wr(21'h0, 8'hD0);
        chk("R7 resume", start_resume, 1'b1);
        rd(21'h0, v);
        chk("R7 resumed csr", v, 8'h80);
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        wr(21'h0, 8'hB0);
        chk("R7 idle suspend ignored", start_suspend, 1'b0);
        chk("R7 idle suspend mode", rd_mode, 2'd2);

        // R6 bad confirm
        wr(21'h0, 8'h20);
        wr(21'h0, 8'h55);
        chk("R6 no erase", start_erase, 1'b0);
        chk("R6 mode array", rd_mode, 2'd0);
        wr(21'h0, 8'h70);
        rd(21'h0, v);
        chk("R6 csr bits", v, 8'hB0);
        wr(21'h0, 8'h71);
        rd(21'h000001, v);
        chk("R6 gsr bit", v, 8'hA0);

        // R10 clear
        wr(21'h0, 8'h50);
        wr(21'h0, 8'h70);
        rd(21'h0, v);
        chk("R10 csr cleared", v, 8'h80);
        wr(21'h0, 8'h71);
        rd(21'h000001, v);
        chk("R10 gsr cleared", v, 8'h80);

        // R8 lock protection
        wp_n = 1'b0;
        wr(21'h0, 8'h40);
        wr(21'h030010, 8'h11);
        chk("R8 locked write blocked", start_write, 1'b0);
        rd(21'h0, v);
        chk("R8 write err csr", v, 8'h90);
        wr(21'h0, 8'h71);
        rd(21'h030000, v);
        chk("R8 block err bit", v, 8'hE0);
        wr(21'h0, 8'h50);
        wr(21'h0, 8'h20);
        wr(21'h030000, 8'hD0);
        chk("R8 locked erase blocked", start_erase, 1'b0);
        rd(21'h0, v);
        chk("R8 erase err csr", v, 8'hA0);
        wr(21'h0, 8'h50);
        wp_n = 1'b1;
        wr(21'h0, 8'h40);
        wr(21'h030010, 8'h11);
        chk("R8 override write", start_write, 1'b1);

        // R9 lock upload
        lock_nv = 32'h0000_0020;
        wr(21'h0, 8'h71);
        wr(21'h0, 8'h97);
        chk("R9 upload keeps mode", rd_mode, 2'd3);
        rd(21'h030000, v);
        chk("R9 block3 unlocked", v, 8'h80);
        rd(21'h050000, v);
        chk("R9 block5 locked", v, 8'hC0);
        wp_n = 1'b0;
        wr(21'h0, 8'h40);
        wr(21'h030000, 8'h22);
        chk("R9 unlocked write", start_write, 1'b1);
        wr(21'h0, 8'h71);
        wr(21'h0, 8'h50);
        chk("R10 clear keeps mode", rd_mode, 2'd3);
        rd(21'h050000, v);
        chk("R10 clear keeps lock", v, 8'hC0);
        wp_n = 1'b1;

        // R12 ready bit
        eng_busy = 1'b1;
        wr(21'h0, 8'h70);
        rd(21'h0, v);
        chk("R12 csr busy", v, 8'h00);
        wr(21'h0, 8'h71);
        rd(21'h000001, v);
        chk("R12 gsr busy", v, 8'h00);
        rd(21'h050000, v);
        chk("R12 bsr busy", v, 8'h40);
        eng_busy = 1'b0;

        // R11 reset drops pending sequence and relocks
        wr(21'h0, 8'h40);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11 mode after reset", rd_mode, 2'd0);
        wr(21'h050000, 8'h3C);
        chk("R11 pending dropped", start_write, 1'b0);
        wr(21'h0, 8'h71);
        rd(21'h030000, v);
        chk("R11 relocked", v, 8'hC0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule